// File: doc/BRIEF.md
# LPC Serial Interrupt Aggregator

This block takes up to sixteen interrupt request lines, already decoded from an LPC serial-IRQ stream, and combines them into one level-sensitive interrupt toward the host. The requests pass through two sticky latches in a row, and software must acknowledge each one. The first latch sits at the controller level. A rising request line sets a status bit there. That status is masked and then gated by a global serial-IRQ enable, and the result is one controller interrupt line. The second latch sits at the on-chip-bus master level. It samples the controller line through its own mask into a second status register. The host interrupt is asserted while that register holds any set bit.

Software reaches every register through a synchronous 32-bit register port. A write is applied one cycle after it is presented. Read data is registered and appears in the cycle after the read strobe. Both latches are evaluated every cycle. As a result, a bus-level status bit that software clears while its masked input is still active stays set. A polarity register exists at the bus level, but it only stores a value and has no effect on interrupt evaluation.

Top module: `lpc_sirq_aggr`

## Requirements
- R1: A rising edge on request line n (a high level in this cycle after a low level in the previous cycle) sets controller status bit 31-n at the next clock edge, so line 0 maps to bit 31 and line 15 maps to bit 16.
- R2: Once a controller status bit is set, it stays set while its line is low or held high. Only a software write can clear it.
- R3: A write to the controller status register (address 2) clears every bit written as 1 and leaves the other bits unchanged. If a rising edge and a clear reach the same bit in the same cycle, the bit ends up set.
- R4: The controller interrupt line is high exactly when control bit 31 (the serial-IRQ enable, control register at address 0) is set and the controller status ANDed with the controller mask (address 1) is nonzero. Reading the bus input register (address 3) returns this line's live value in bit 0, with all other bits zero.
- R5: The bus input register is read-only. A write to address 3 changes no register and no output.
- R6: Every cycle, the bus status register (address 4) ORs in the bus input ANDed with the bus mask (address 5). Writing 1s to address 4 clears those bits. A bit whose masked input is still active reads back set after the clear.
- R7: The host interrupt output is high exactly when the bus status register is nonzero.
- R8: The bus polarity register (address 6) reads back the last value written to it and has no effect on any interrupt state or output.
- R9: After reset, every register reads zero and the host interrupt is low. Address 7 always reads zero.
- R10: A read returns the addressed register in the cycle after the read strobe. Reads change no state, and the read data holds its value while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | Decoded per-line serial IRQ levels |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| host_irq | output | 1 | Level interrupt toward the host |

## Verification
The assertions check five things on every cycle:
- a rising request line sets its mapped controller status bit;
- controller status bits never drop unless a status write occurs;
- a status write clears its bits when no rise competes;
- an active masked controller line always lands in the bus status;
- the host interrupt stays high until a bus status write.

Only the bench's scenarios can show the rest:
- the bit-reversed line mapping at both ends;
- read-only treatment of the input register;
- the inertness of the polarity register;
- the precedence of a set over a clear in the same cycle;
- immediate re-latching after a bus status clear.

The bench's per-cycle reference model also compares every read.

// File: rtl/lpc_sirq_pkg.sv
package lpc_sirq_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 3'd0,
        A_CMASK = 3'd1,
        A_CSTAT = 3'd2,
        A_BIN   = 3'd3,
        A_BSTAT = 3'd4,
        A_BMASK = 3'd5,
        A_BPOL  = 3'd6,
        A_NONE  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic ctrl;
        logic cmask;
        logic cstat;
        logic bstat;
        logic bmask;
        logic bpol;
    } wr_strobe_t;

endpackage

// File: rtl/lpc_sirq_regport.sv
module lpc_sirq_regport
    import lpc_sirq_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] ctrl_q,
    input  logic [DW-1:0] cmask_q,
    input  logic [DW-1:0] cstat_q,
    input  logic [DW-1:0] bin_live,
    input  logic [DW-1:0] bstat_q,
    input  logic [DW-1:0] bmask_q,
    input  logic [DW-1:0] bpol_q,
    output wr_strobe_t    wr_stb,
    output logic [DW-1:0] reg_rdata
);

    reg_addr_e       sel;
    logic [DW-1:0]   rd_mux;

    assign sel = reg_addr_e'(reg_addr);

    // Write decode: one strobe per writable register; the input register has none.
    always_comb begin
        wr_stb = '0;
        if (reg_wr) begin
            unique case (sel)
                A_CTRL:  wr_stb.ctrl  = 1'b1;
                A_CMASK: wr_stb.cmask = 1'b1;
                A_CSTAT: wr_stb.cstat = 1'b1;
                A_BSTAT: wr_stb.bstat = 1'b1;
                A_BMASK: wr_stb.bmask = 1'b1;
                A_BPOL:  wr_stb.bpol  = 1'b1;
                default: wr_stb = '0;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            A_CTRL:  rd_mux = ctrl_q;
            A_CMASK: rd_mux = cmask_q;
            A_CSTAT: rd_mux = cstat_q;
            A_BIN:   rd_mux = bin_live;
            A_BSTAT: rd_mux = bstat_q;
            A_BMASK: rd_mux = bmask_q;
            A_BPOL:  rd_mux = bpol_q;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/lpc_sirq_ctrl_stage.sv
module lpc_sirq_ctrl_stage #(
    parameter int NUM_LINES = 16,
    parameter int DW        = 32,
    parameter int BASE_BIT  = 31,
    parameter int EN_BIT    = 31
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 wr_ctrl,
    input  logic                 wr_cmask,
    input  logic                 wr_cstat,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        ctrl_q,
    output logic [DW-1:0]        cmask_q,
    output logic [DW-1:0]        cstat_q,
    output logic                 ctrl_line
);

    localparam int LOW_BIT = BASE_BIT - (NUM_LINES - 1);

    logic [NUM_LINES-1:0] prev_q;
    logic [DW-1:0]        rise_vec;
    logic [DW-1:0]        clr_vec;

    // Line n lands MSB-first: BASE_BIT - n.
    always_comb begin
        rise_vec = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            rise_vec[BASE_BIT-i] = irq_lines[i] & ~prev_q[i];
        end
    end

    assign clr_vec   = wr_cstat ? wdata : '0;
    assign ctrl_line = ctrl_q[EN_BIT] && ((cstat_q & cmask_q) != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            ctrl_q  <= '0;
            cmask_q <= '0;
            cstat_q <= '0;
        end else begin
            prev_q  <= irq_lines;
            // A new edge wins over a same-cycle clear.
            cstat_q <= (cstat_q & ~clr_vec) | rise_vec;
            if (wr_ctrl)  ctrl_q  <= wdata;
            if (wr_cmask) cmask_q <= wdata;
        end
    end

    initial begin
        if (LOW_BIT < 0) $error("line map does not fit below BASE_BIT");
    end

endmodule

// File: rtl/lpc_sirq_bus_stage.sv
module lpc_sirq_bus_stage #(
    parameter int DW      = 32,
    parameter int LPC_BIT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_line,
    input  logic          wr_bstat,
    input  logic          wr_bmask,
    input  logic          wr_bpol,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] bin_live,
    output logic [DW-1:0] bstat_q,
    output logic [DW-1:0] bmask_q,
    output logic [DW-1:0] bpol_q,
    output logic          host_irq
);

    typedef enum logic [0:0] { S_QUIET = 1'b0, S_RAISED = 1'b1 } host_state_e;

    host_state_e   state_q;
    host_state_e   state_d;
    logic [DW-1:0] clr_vec;
    logic [DW-1:0] bstat_d;

    always_comb begin
        bin_live          = '0;
        bin_live[LPC_BIT] = ctrl_line;
    end

    assign clr_vec = wr_bstat ? wdata : '0;
    // Sampling in the same cycle as the clear re-latches any still-active input.
    assign bstat_d = (bstat_q & ~clr_vec) | (bin_live & bmask_q);

    always_comb begin
        unique case (state_q)
            S_QUIET:  state_d = (bstat_d != '0) ? S_RAISED : S_QUIET;
            S_RAISED: state_d = (bstat_d == '0) ? S_QUIET  : S_RAISED;
            default:  state_d = S_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_QUIET;
            bstat_q <= '0;
            bmask_q <= '0;
            bpol_q  <= '0;
        end else begin
            state_q <= state_d;
            bstat_q <= bstat_d;
            if (wr_bmask) bmask_q <= wdata;
            if (wr_bpol)  bpol_q  <= wdata;
        end
    end

    always_comb begin
        host_irq = (state_q == S_RAISED);
    end

endmodule

// File: rtl/lpc_sirq_aggr.sv
module lpc_sirq_aggr
    import lpc_sirq_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int BASE_BIT  = 31,
    parameter int EN_BIT    = 31,
    parameter int LPC_BIT   = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 host_irq
);

    wr_strobe_t        wr_stb;
    logic [DATA_W-1:0] ctrl_q, cmask_q, cstat_q;
    logic [DATA_W-1:0] bin_live, bstat_q, bmask_q, bpol_q;
    logic              ctrl_line;

    lpc_sirq_regport #(.DW(DATA_W), .AW(ADDR_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .ctrl_q    (ctrl_q),
        .cmask_q   (cmask_q),
        .cstat_q   (cstat_q),
        .bin_live  (bin_live),
        .bstat_q   (bstat_q),
        .bmask_q   (bmask_q),
        .bpol_q    (bpol_q),
        .wr_stb    (wr_stb),
        .reg_rdata (reg_rdata)
    );

    lpc_sirq_ctrl_stage #(
        .NUM_LINES (NUM_LINES),
        .DW        (DATA_W),
        .BASE_BIT  (BASE_BIT),
        .EN_BIT    (EN_BIT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .wr_ctrl   (wr_stb.ctrl),
        .wr_cmask  (wr_stb.cmask),
        .wr_cstat  (wr_stb.cstat),
        .wdata     (reg_wdata),
        .ctrl_q    (ctrl_q),
        .cmask_q   (cmask_q),
        .cstat_q   (cstat_q),
        .ctrl_line (ctrl_line)
    );

    lpc_sirq_bus_stage #(.DW(DATA_W), .LPC_BIT(LPC_BIT)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_line (ctrl_line),
        .wr_bstat  (wr_stb.bstat),
        .wr_bmask  (wr_stb.bmask),
        .wr_bpol   (wr_stb.bpol),
        .wdata     (reg_wdata),
        .bin_live  (bin_live),
        .bstat_q   (bstat_q),
        .bmask_q   (bmask_q),
        .bpol_q    (bpol_q),
        .host_irq  (host_irq)
    );

endmodule

// File: rtl/lpc_sirq_aggr_chk.sv
module lpc_sirq_aggr_chk
    import lpc_sirq_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int BASE_BIT  = 31,
    parameter int LPC_BIT   = 0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic                 reg_wr,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [DATA_W-1:0]    reg_wdata,
    input logic [DATA_W-1:0]    cstat_q,
    input logic [DATA_W-1:0]    bstat_q,
    input logic [DATA_W-1:0]    bmask_q,
    input logic                 ctrl_line,
    input logic                 host_irq
);

    logic [NUM_LINES-1:0] seen_q;
    logic [DATA_W-1:0]    edge_bits;
    logic                 cstat_wr, bstat_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= irq_lines;
    end

    always_comb begin
        edge_bits = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (irq_lines[i] && !seen_q[i]) edge_bits[BASE_BIT-i] = 1'b1;
        end
    end

    assign cstat_wr = reg_wr && (reg_addr == A_CSTAT);
    assign bstat_wr = reg_wr && (reg_addr == A_BSTAT);

    p_edge_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_bits != '0) |=> ((cstat_q & $past(edge_bits)) == $past(edge_bits)));

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cstat_wr |=> ((cstat_q & $past(cstat_q)) == $past(cstat_q)));

    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cstat_wr && edge_bits == '0) |=> ((cstat_q & $past(reg_wdata)) == '0));

    p_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_line && bmask_q[LPC_BIT]) |=> bstat_q[LPC_BIT]);

    p_host_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq && !bstat_wr) |=> host_irq);

endmodule

bind lpc_sirq_aggr lpc_sirq_aggr_chk #(
    .NUM_LINES (NUM_LINES),
    .BASE_BIT  (BASE_BIT),
    .LPC_BIT   (LPC_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cstat_q   (cstat_q),
    .bstat_q   (bstat_q),
    .bmask_q   (bmask_q),
    .ctrl_line (ctrl_line),
    .host_irq  (host_irq)
);

// File: tb/sim_lpc_sirq_aggr.sv
module sim_lpc_sirq_aggr;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_lines = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        host_irq;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cycles  = 0;
    bit    done    = 1'b0;
    string req_tag = "R9";

    // Behavioural reference state
    logic [31:0] m_ctrl, m_cmask, m_cstat, m_bstat, m_bmask, m_bpol, m_rdata;
    logic [15:0] m_prev;

    lpc_sirq_aggr u0 (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_irq(host_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic m_line();
        return m_ctrl[31] && ((m_cstat & m_cmask) != 0);
    endfunction

    always @(posedge clk) begin
        logic        ln;
        logic [31:0] rv;
        logic [31:0] sets;
        if (!rst_n) begin
            m_ctrl = 0; m_cmask = 0; m_cstat = 0; m_bstat = 0;
            m_bmask = 0; m_bpol = 0; m_rdata = 0; m_prev = 0;
        end else begin
            ln = m_line();
            if (reg_rd) begin
                case (reg_addr)
                    3'd0: rv = m_ctrl;
                    3'd1: rv = m_cmask;
                    3'd2: rv = m_cstat;
                    3'd3: rv = {31'd0, ln};
                    3'd4: rv = m_bstat;
                    3'd5: rv = m_bmask;
                    3'd6: rv = m_bpol;
                    default: rv = 0;
                endcase
                m_rdata = rv;
            end
            sets = 0;
            for (int i = 0; i < 16; i++)
                if (irq_lines[i] && !m_prev[i]) sets = sets | (32'h8000_0000 >> i);
            if (reg_wr && reg_addr == 3'd4) m_bstat = m_bstat & ~reg_wdata;
            if (ln) m_bstat = m_bstat | (m_bmask & 32'd1);
            if (reg_wr && reg_addr == 3'd2) m_cstat = m_cstat & ~reg_wdata;
            m_cstat = m_cstat | sets;
            if (reg_wr && reg_addr == 3'd0) m_ctrl  = reg_wdata;
            if (reg_wr && reg_addr == 3'd1) m_cmask = reg_wdata;
            if (reg_wr && reg_addr == 3'd5) m_bmask = reg_wdata;
            if (reg_wr && reg_addr == 3'd6) m_bpol  = reg_wdata;
            m_prev = irq_lines;
        end
    end

    task automatic check(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
        end
    endtask

    // Compare against the model on every cycle, away from the edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(req_tag, "host_irq vs model", {31'd0, host_irq}, {31'd0, (m_bstat != 0)});
            check(req_tag, "rdata vs model", reg_rdata, m_rdata);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <%0d cycles", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        check(tag, $sformatf("read addr %0d", a), reg_rdata, exp);
    endtask

    task automatic pulse(input int n);
        irq_lines[n] = 1'b1;
        @(negedge clk);
        irq_lines[n] = 1'b0;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        req_tag = "R9";
        check("R9", "host after reset", {31'd0, host_irq}, 32'd0);
        for (int a = 0; a < 8; a++) rd(3'(a), 32'd0, "R9");

        // R1: MSB-first mapping at both ends
        req_tag = "R1";
        pulse(0);
        rd(3'd2, 32'h8000_0000, "R1");
        pulse(15);
        rd(3'd2, 32'h8001_0000, "R1");

        // R2: held and falling lines do not clear
        req_tag = "R2";
        irq_lines[3] = 1'b1;
        idle(4);
        irq_lines[3] = 1'b0;
        idle(2);
        rd(3'd2, 32'h9001_0000, "R2");

        // R4: enable gating, visible through the input register
        req_tag = "R4";
        wr(3'd1, 32'h0001_0000);
        rd(3'd3, 32'd0, "R4");
        wr(3'd0, 32'h8000_0000);
        rd(3'd3, 32'd1, "R4");
        rd(3'd0, 32'h8000_0000, "R10");
        wr(3'd1, 32'h0000_FFFF);
        rd(3'd3, 32'd0, "R4");
        wr(3'd1, 32'hFFFF_FFFF);

        // R6/R7: bus latch raises host
        req_tag = "R6";
        check("R7", "host low before bus mask", {31'd0, host_irq}, 32'd0);
        wr(3'd5, 32'd1);
        idle(1);
        check("R7", "host high after bus mask", {31'd0, host_irq}, 32'd1);
        rd(3'd4, 32'd1, "R6");

        // R6: clear while input active re-latches
        wr(3'd4, 32'd1);
        check("R6", "host after clear with active input", {31'd0, host_irq}, 32'd1);
        rd(3'd4, 32'd1, "R6");

        // R7: disable source, stays sticky, then clear drops host
        req_tag = "R7";
        wr(3'd0, 32'd0);
        idle(2);
        check("R7", "host sticky after disable", {31'd0, host_irq}, 32'd1);
        wr(3'd4, 32'hFFFF_FFFF);
        check("R7", "host after clear", {31'd0, host_irq}, 32'd0);

        // R5: input register is read-only
        req_tag = "R5";
        wr(3'd3, 32'hFFFF_FFFF);
        idle(1);
        rd(3'd3, 32'd0, "R5");
        check("R5", "host after input write", {31'd0, host_irq}, 32'd0);

        // R3: write-one-to-clear
        req_tag = "R3";
        wr(3'd2, 32'h8000_0000);
        rd(3'd2, 32'h1001_0000, "R3");
        // same-cycle rise and clear on line 4 (bit 27): set wins
        irq_lines[4] = 1'b1;
        reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h0800_0000;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; irq_lines[4] = 1'b0;
        rd(3'd2, 32'h1801_0000, "R3");

        // R10: repeated reads have no side effects, rdata holds
        req_tag = "R10";
        rd(3'd2, 32'h1801_0000, "R10");
        idle(3);
        check("R10", "rdata hold", reg_rdata, 32'h1801_0000);

        // R8: polarity stored but inert
        req_tag = "R8";
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd6, 32'hFFFF_FFFF, "R8");
        idle(2);
        check("R8", "host with polarity set, source off", {31'd0, host_irq}, 32'd0);
        wr(3'd0, 32'h8000_0000);
        idle(1);
        check("R8", "host with polarity set, source on", {31'd0, host_irq}, 32'd1);
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd4, 32'hFFFF_FFFF);
        idle(1);
        check("R8", "host after full clear", {31'd0, host_irq}, 32'd0);
        rd(3'd6, 32'hFFFF_FFFF, "R8");

        // R9 address 7 reads zero
        rd(3'd7, 32'd0, "R9");
        idle(3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule